// File: doc/BRIEF.md
# Dynamic priority rank shuffler

This block hands out priority ranks to a group of threads that a memory scheduler treats as equally critical, and decides when those ranks are redrawn. The threads in the group are named by a membership mask. Every rank held by a member is moved to a new random position among the members. The ranks of non-members are never touched, so the full rank vector is always a permutation of 0 to NTHR-1.

Time is split into monitoring intervals. An interval closes once each member thread has retired a set number of instructions. When an interval closes, the block compares the memory intensities the members report. If the intensities are close together, the next interval uses code-segment mode: ranks are held until a member crosses a synchronisation point (a lock acquire, a lock release or a barrier), which it signals with a pulse. If the intensities are far apart, the next interval uses time-based mode: ranks are redrawn on a fixed cycle period.

Every redraw raises a single-cycle pulse on `reshuf`. The new ranking is produced by a swap sequence driven by an LFSR, one swap per cycle.

Top module: `rank_shuffler`

## Requirements
- R1: During and right after reset, thread i holds rank i, `mode_seg` is 0 (time-based mode) and `reshuf` is 0.
- R2: At every clock, the ranks of all threads form a permutation of 0..NTHR-1. A redraw only exchanges ranks between member threads, and it completes within NTHR-1 cycles after the `reshuf` pulse.
- R3: A thread whose `member` bit is 0 keeps its rank across redraws.
- R4: An interval closes in the cycle after every member thread has retired at least INSN_TARGET instructions since the interval began. `retire` pulses from non-members are ignored. Each close starts a new interval and triggers a redraw.
- R5: At an interval close, `mode_seg` becomes 1 when, over member threads only, the smallest intensity is non-zero and max×5 < min×6. Otherwise `mode_seg` becomes 0. `mode_seg` changes only together with a `reshuf` pulse.
- R6: In time-based mode, a redraw fires every PERIOD cycles. The cycle count restarts at each interval close.
- R7: In code-segment mode, a `seg_chg` pulse from a member triggers a redraw. `seg_chg` from a non-member has no effect. The periodic timer does not fire in this mode.
- R8: `reshuf` is high for exactly one cycle. It rises in the cycle after the triggering condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | NTHR | Per-thread instruction-retired pulse |
| intensity | input | NTHR*IW | Per-thread memory intensity; thread i occupies bits [i*IW +: IW] |
| seg_chg | input | NTHR | Per-thread code-segment change pulse |
| member | input | NTHR | Group membership mask |
| rank | output | NTHR*RW | Per-thread rank; thread i occupies bits [i*RW +: RW] |
| mode_seg | output | 1 | 1 = code-segment mode, 0 = time-based mode |
| reshuf | output | 1 | One-cycle pulse marking the start of a new ranking |

## Verification
The mode decision is tested with intensity sets chosen to separate the cases:
- identical values;
- a spread just under the 1.2 ratio;
- a spread landing exactly on it;
- a zero among the members;
- an extreme value or a zero held by a thread outside the mask, which must be ignored.

The interval-close rule is tested with retirement from only part of the group, which must not close the interval, and then with the last thread completing it. Triggers are told apart by:
- a segment change from a non-member against one from a member;
- a long idle stretch in code-segment mode;
- the spacing of pulses in time-based mode.

// File: rtl/rank_shuffler.sv
module rank_shuffler #(
  parameter int NTHR        = 4,
  parameter int IW          = 16,
  parameter int INSN_TARGET = 5000,
  parameter int PERIOD      = 100000,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NTHR-1:0]              retire,
  input  logic [NTHR*IW-1:0]           intensity,
  input  logic [NTHR-1:0]              seg_chg,
  input  logic [NTHR-1:0]              member,
  output logic [NTHR*((NTHR>1)?$clog2(NTHR):1)-1:0] rank,
  output logic                         mode_seg,
  output logic                         reshuf
);
  localparam int RW = (NTHR > 1) ? $clog2(NTHR) : 1;
  localparam int CW = $clog2(INSN_TARGET + 1);
  localparam int TW = $clog2(PERIOD);
  localparam int MW = IW + 3;

  logic [CW-1:0]   icnt [NTHR];
  logic [RW-1:0]   rk   [NTHR];
  logic [NTHR-1:0] reached;
  logic [TW-1:0]   tmr;
  logic [15:0]     lfsr, modv;
  logic [RW-1:0]   sh_idx, jsel;
  logic [IW-1:0]   mx, mn;
  logic            done_all, far, tmr_hit, trig;

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    assign reached[g] = (icnt[g] == CW'(INSN_TARGET));
    assign rank[g*RW +: RW] = rk[g];
    always_ff @(posedge clk) begin
      if (!rst_n || done_all) icnt[g] <= '0;
      else if (member[g] && retire[g] && !reached[g]) icnt[g] <= icnt[g] + 1'b1;
    end
  end

  always_comb begin
    mx = '0;
    mn = '1;
    for (int i = 0; i < NTHR; i++) begin
      if (member[i]) begin
        if (intensity[i*IW +: IW] > mx) mx = intensity[i*IW +: IW];
        if (intensity[i*IW +: IW] < mn) mn = intensity[i*IW +: IW];
      end
    end
  end

  assign far      = (mn == '0) || (MW'(mx) * MW'(5) >= MW'(mn) * MW'(6));
  assign done_all = (|member) && (&(reached | ~member));
  assign tmr_hit  = !mode_seg && (tmr == TW'(PERIOD - 1));
  assign trig     = done_all || tmr_hit || (mode_seg && |(seg_chg & member));
  assign modv     = lfsr % (16'(sh_idx) + 16'd1);
  assign jsel     = modv[RW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      lfsr     <= SEED;
      sh_idx   <= '0;
      mode_seg <= 1'b0;
      reshuf   <= 1'b0;
      for (int i = 0; i < NTHR; i++) rk[i] <= RW'(i);
    end else begin
      lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reshuf <= trig;
      if (done_all) mode_seg <= !far;
      tmr <= (done_all || tmr_hit || mode_seg) ? '0 : tmr + 1'b1;
      if (trig) sh_idx <= RW'(NTHR - 1);
      else if (sh_idx != '0) begin
        sh_idx <= sh_idx - 1'b1;
        if (member[sh_idx] && member[jsel]) begin
          rk[sh_idx] <= rk[jsel];
          rk[jsel]   <= rk[sh_idx];
        end
      end
    end
  end
endmodule

module rank_shuffler_chk #(
  parameter int NTHR = 4,
  parameter int RW   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NTHR-1:0]      seg_chg,
  input logic [NTHR-1:0]      member,
  input logic [NTHR*RW-1:0]   rank,
  input logic                 mode_seg,
  input logic                 reshuf
);
  logic [NTHR-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NTHR; i++) seen[rank[i*RW +: RW]] = 1'b1;
  end

  assert_rank_perm_R2: assert property (@(posedge clk) disable iff (!rst_n) &seen);

  for (genvar g = 0; g < NTHR; g++) begin : g_hold
    assert_nonmember_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !member[g] |=> rank[g*RW +: RW] == $past(rank[g*RW +: RW]));
  end

  assert_mode_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_seg != $past(mode_seg)) |-> reshuf);

  assert_seg_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_seg && |(seg_chg & member)) |=> reshuf);
endmodule

bind rank_shuffler rank_shuffler_chk #(.NTHR(NTHR), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_chg(seg_chg), .member(member),
  .rank(rank), .mode_seg(mode_seg), .reshuf(reshuf));

// File: tb/sim_rank_shuffler.sv
module sim_rank_shuffler;
  localparam int N = 4, IW = 8, T = 6, P = 40, RW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] retire = '0, seg_chg = '0, member = '0;
  logic [N*IW-1:0] intensity = '0;
  logic [N*RW-1:0] rank;
  logic mode_seg, reshuf;

  rank_shuffler #(.NTHR(N), .IW(IW), .INSN_TARGET(T), .PERIOD(P)) u0 (
    .clk(clk), .rst_n(rst_n), .retire(retire), .intensity(intensity),
    .seg_chg(seg_chg), .member(member), .rank(rank), .mode_seg(mode_seg), .reshuf(reshuf));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, pulses = 0, last_t = 0, prev_t = 0, dbl = 0;
  logic prev_r = 0;

  always @(negedge clk) begin
    cyc++;
    if (reshuf) begin pulses++; prev_t = last_t; last_t = cyc; end
    if (reshuf && prev_r) dbl++;
    prev_r = reshuf;
    if (cyc > 60000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cyc=%0d expected <60000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic bit is_perm(logic [N*RW-1:0] r);
    logic [N-1:0] s = '0;
    for (int i = 0; i < N; i++) s[r[i*RW +: RW]] = 1'b1;
    return &s;
  endfunction

  // {mask, i3, i2, i1, i0, expected mode_seg}
  localparam logic [36:0] TBL [8] = '{
    {4'hF, 8'd100, 8'd100, 8'd100, 8'd100, 1'b1},
    {4'hF, 8'd100, 8'd119, 8'd110, 8'd105, 1'b1},
    {4'hF, 8'd120, 8'd100, 8'd110, 8'd100, 1'b0},
    {4'hF, 8'd0,   8'd50,  8'd50,  8'd50,  1'b0},
    {4'h7, 8'd200, 8'd100, 8'd100, 8'd100, 1'b1},
    {4'hE, 8'd50,  8'd50,  8'd50,  8'd0,   1'b1},
    {4'hF, 8'd50,  8'd50,  8'd50,  8'd0,   1'b0},
    {4'hF, 8'd10,  8'd10,  8'd10,  8'd10,  1'b1}
  };

  initial begin
    int p0;
    logic [RW-1:0] r0;
    tick(3);
    for (int i = 0; i < N; i++) check(rank[i*RW +: RW] == RW'(i), "R1 rank", int'(rank[i*RW +: RW]), i);
    check(mode_seg == 0, "R1 mode", int'(mode_seg), 0);
    check(reshuf == 0, "R1 reshuf", int'(reshuf), 0);
    rst_n = 1;
    tick(2);

    for (int k = 0; k < 8; k++) begin
      member = TBL[k][36:33];
      intensity = TBL[k][32:1];
      p0 = pulses;
      retire = '1;
      tick(T + 1);
      retire = '0;
      tick(N + 1);
      check(mode_seg == TBL[k][0], "R5 mode select", int'(mode_seg), int'(TBL[k][0]));
      check(pulses > p0, "R4 interval close pulse", pulses, p0 + 1);
      check(is_perm(rank), "R2 permutation", int'(rank), 0);
    end

    p0 = pulses;
    retire = 4'b0111;
    tick(T + 2);
    retire = '0;
    tick(3);
    check(pulses == p0, "R4 partial retire no close", pulses, p0);
    retire = 4'b1000;
    tick(T + 1);
    retire = '0;
    tick(3);
    check(pulses == p0 + 1, "R4 last thread closes", pulses, p0 + 1);

    member = 4'hE;
    tick(N);
    r0 = rank[RW-1:0];
    p0 = pulses;
    seg_chg = 4'b0001;
    tick(1);
    seg_chg = '0;
    tick(5);
    check(pulses == p0, "R7 non-member seg_chg ignored", pulses, p0);
    tick(3 * P);
    check(pulses == p0, "R7 no timer in segment mode", pulses, p0);
    for (int k = 0; k < 3; k++) begin
      seg_chg = 4'b0010 << k;
      tick(1);
      check(reshuf == 1, "R8 pulse one cycle after trigger", int'(reshuf), 1);
      seg_chg = '0;
      tick(1);
      check(reshuf == 0, "R8 pulse width", int'(reshuf), 0);
      tick(N);
      check(is_perm(rank), "R2 permutation after redraw", int'(rank), 0);
      check(rank[RW-1:0] == r0, "R3 non-member rank held", int'(rank[RW-1:0]), int'(r0));
    end
    check(pulses == p0 + 3, "R7 member seg_chg count", pulses, p0 + 3);

    member = 4'hF;
    intensity = {8'd40, 8'd40, 8'd40, 8'd0};
    retire = '1;
    tick(T + 1);
    retire = '0;
    tick(2);
    check(mode_seg == 0, "R5 zero min selects time mode", int'(mode_seg), 0);
    p0 = pulses;
    while (pulses < p0 + 2) tick(1);
    check(last_t - prev_t == P, "R6 time period", last_t - prev_t, P);
    check(dbl == 0, "R8 no double pulse", dbl, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule